// File: doc/BRIEF.md
# Host-Side Serial Link Bring-Up Controller

This block sequences the start-up of a host-side serial storage link. It first runs an out-of-band exchange. It asks the transceiver wrapper to emit a reset burst and waits for the device's init burst. It then requests a wake burst and waits for the device's wake answer. After that it switches to in-band signalling: a steady D10.2 pattern, then ALIGN primitives. It ends the exchange once a run of SYNC primitives arrives. At that point it raises a PHY-ready flag and keeps transmitting ALIGN and SYNC in turn.

The wrapper tells the controller when a requested burst has been sent (`burst_done_i`). It also gives single-cycle pulses when it detects an init or wake burst from the device. Transmit and receive paths are 32-bit dwords, each with a control-character flag. Both waiting windows are parameters counted in clock cycles. The recovery paths are fixed. A missing init burst re-issues the reset burst. A missing ALIGN sends the controller back to its idle state. Once up, the link is dropped on a fresh init burst or on a malformed control word.

Top module: `link_oob_ctrl`

## Requirements
- R1: During and after reset the controller is idle: `comreset_req_o` is 1, `comwake_req_o` and `phy_rdy_o` are 0, and the transmit word is 0 with flag 0. It leaves idle on `burst_done_i`.
- R2: After the reset burst, the controller waits for `cominit_det_i` for INIT_CYC cycles. If none comes, it returns to idle and requests the reset burst again. A pulse in the last cycle of the window is still accepted.
- R3: On `cominit_det_i` it holds `comwake_req_o` high until `burst_done_i`, then waits for `comwake_det_i` with no time limit. Throughout all out-of-band states the transmit word is 0 with flag 0, and wake pulses before the wake request completes are ignored.
- R4: The cycle after `comwake_det_i` it transmits 0x4A4A4A4A with the flag clear, on every cycle until ALIGN is seen.
- R5: A received ALIGN (0x7B4A4ABC, flag 1) within ALIGN_CYC cycles of the start of D10.2 moves it on. Otherwise it returns to idle.
- R6: In the ALIGN phase it transmits 0x7B4A4ABC with flag 1. It advances only after three SYNC dwords (0xB5B5957C, flag 1) received on consecutive cycles. Any other dword restarts the count.
- R7: `phy_rdy_o` is 1 exactly while the link is up. It rises on the cycle after the third consecutive SYNC.
- R8: While up, the transmit word alternates each cycle, starting with ALIGN and then SYNC, both with flag 1.
- R9: While up, a received dword with flag 1 whose low byte is neither 0xBC nor 0x7C drops `phy_rdy_o` and returns to idle. Dwords with flag 0 do not.
- R10: While up, a `cominit_det_i` pulse drops `phy_rdy_o` and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| burst_done_i | input | 1 | Wrapper finished the requested burst |
| cominit_det_i | input | 1 | Pulse: device init burst detected |
| comwake_det_i | input | 1 | Pulse: device wake burst detected |
| rx_data_i | input | 32 | Received dword |
| rx_ctrl_i | input | 1 | Received dword is a control character |
| comreset_req_o | output | 1 | Request reset burst |
| comwake_req_o | output | 1 | Request wake burst |
| tx_data_o | output | 32 | Transmit dword |
| tx_ctrl_o | output | 1 | Transmit dword is a control character |
| phy_rdy_o | output | 1 | Link established |

## Verification
The hardest case to reach is the edge of each wait window: an init pulse in the very last cycle of the window, which must still be accepted. The bench counts exactly INIT_CYC-1 idle cycles after the reset burst before giving the pulse, with short window parameters. The SYNC run is also reached only by breaking it deliberately. A run of two SYNC words is interrupted by an ALIGN, and a SYNC with a clear flag is sent, before the full run of three. A cycle reference model compares every output on every clock, so an early or late transition shows as a mismatch in that exact cycle.

// File: rtl/oob_pkg.sv
package oob_pkg;
  localparam logic [31:0] PRIM_ALIGN = 32'h7B4A4ABC;
  localparam logic [31:0] PRIM_SYNC  = 32'hB5B5957C;
  localparam logic [31:0] PAT_D102   = 32'h4A4A4A4A;
  localparam logic [7:0]  K_ALIGN_LO = 8'hBC;
  localparam logic [7:0]  K_SYNC_LO  = 8'h7C;

  typedef enum logic [2:0] {
    ST_RESET     = 3'd0,
    ST_WAIT_INIT = 3'd1,
    ST_WAKE      = 3'd2,
    ST_WAIT_WAKE = 3'd3,
    ST_D102      = 3'd4,
    ST_ALIGN     = 3'd5,
    ST_LINKUP    = 3'd6
  } oob_state_e;
endpackage

// File: rtl/oob_timer.sv
module oob_timer #(
  parameter int unsigned INIT_CYC  = 2500000,
  parameter int unsigned ALIGN_CYC = 220000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic sel_align_i,
  output logic expired_o
);
  localparam int unsigned MAXC = (INIT_CYC > ALIGN_CYC) ? INIT_CYC : ALIGN_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] INIT_LAST  = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] ALIGN_LAST = CW'(ALIGN_CYC - 1);
  localparam logic [CW-1:0] CNT_MAX    = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == (sel_align_i ? ALIGN_LAST : INIT_LAST));

  // R2
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> cnt_q == '0);
endmodule

// File: rtl/rx_prim_check.sv
module rx_prim_check #(
  parameter int unsigned SYNC_RUN = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] rx_data_i,
  input  logic        rx_ctrl_i,
  input  logic        run_clear_i,
  output logic        align_o,
  output logic        sync_o,
  output logic        sync_done_o,
  output logic        bad_ctrl_o
);
  import oob_pkg::*;
  localparam int unsigned RW = $clog2(SYNC_RUN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(SYNC_RUN - 1);

  logic [RW-1:0] run_q;

  assign align_o     = rx_ctrl_i && (rx_data_i == PRIM_ALIGN);
  assign sync_o      = rx_ctrl_i && (rx_data_i == PRIM_SYNC);
  assign sync_done_o = sync_o && (run_q == RUN_LAST);
  assign bad_ctrl_o  = rx_ctrl_i && (rx_data_i[7:0] != K_ALIGN_LO) &&
                       (rx_data_i[7:0] != K_SYNC_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (run_clear_i) run_q <= '0;
    else if (!sync_o)     run_q <= '0;
    else if (run_q != RUN_LAST) run_q <= run_q + 1'b1;
  end

  // R6
  run_needs_prior_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q != '0) |-> $past(rx_ctrl_i && rx_data_i == PRIM_SYNC));
endmodule

// File: rtl/tx_word_gen.sv
module tx_word_gen (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  oob_pkg::oob_state_e state_i,
  output logic [31:0]         tx_data_o,
  output logic                tx_ctrl_o
);
  import oob_pkg::*;
  logic alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alt_q <= 1'b0;
    else         alt_q <= (state_i == ST_LINKUP) ? ~alt_q : 1'b0;
  end

  always_comb begin
    tx_data_o = '0;
    tx_ctrl_o = 1'b0;
    unique case (state_i)
      ST_D102:   tx_data_o = PAT_D102;
      ST_ALIGN:  begin tx_data_o = PRIM_ALIGN; tx_ctrl_o = 1'b1; end
      ST_LINKUP: begin tx_data_o = alt_q ? PRIM_SYNC : PRIM_ALIGN; tx_ctrl_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/link_oob_ctrl.sv
module link_oob_ctrl #(
  parameter int unsigned INIT_CYC  = 2500000,
  parameter int unsigned ALIGN_CYC = 220000,
  parameter int unsigned SYNC_RUN  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        burst_done_i,
  input  logic        cominit_det_i,
  input  logic        comwake_det_i,
  input  logic [31:0] rx_data_i,
  input  logic        rx_ctrl_i,
  output logic        comreset_req_o,
  output logic        comwake_req_o,
  output logic [31:0] tx_data_o,
  output logic        tx_ctrl_o,
  output logic        phy_rdy_o
);
  import oob_pkg::*;

  oob_state_e state_q, state_d;
  logic expired, rx_align, rx_sync, sync_done, bad_ctrl;

  oob_timer #(.INIT_CYC(INIT_CYC), .ALIGN_CYC(ALIGN_CYC)) u_timer (
    .clk_i, .rst_ni,
    .restart_i  (state_d != state_q),
    .sel_align_i(state_q == ST_D102),
    .expired_o  (expired)
  );

  rx_prim_check #(.SYNC_RUN(SYNC_RUN)) u_rx (
    .clk_i, .rst_ni, .rx_data_i, .rx_ctrl_i,
    .run_clear_i(state_q != ST_ALIGN),
    .align_o    (rx_align),
    .sync_o     (rx_sync),
    .sync_done_o(sync_done),
    .bad_ctrl_o (bad_ctrl)
  );

  tx_word_gen u_tx (
    .clk_i, .rst_ni, .state_i(state_q), .tx_data_o, .tx_ctrl_o
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:     if (burst_done_i) state_d = ST_WAIT_INIT;
      ST_WAIT_INIT: if (cominit_det_i) state_d = ST_WAKE;
                    else if (expired)  state_d = ST_RESET;
      ST_WAKE:      if (burst_done_i) state_d = ST_WAIT_WAKE;
      ST_WAIT_WAKE: if (comwake_det_i) state_d = ST_D102;
      ST_D102:      if (rx_align)     state_d = ST_ALIGN;
                    else if (expired) state_d = ST_RESET;
      ST_ALIGN:     if (sync_done)    state_d = ST_LINKUP;
      ST_LINKUP:    if (cominit_det_i || bad_ctrl) state_d = ST_RESET;
      default:      state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign comreset_req_o = (state_q == ST_RESET);
  assign comwake_req_o  = (state_q == ST_WAKE);
  assign phy_rdy_o      = (state_q == ST_LINKUP);

  // R4
  d102_after_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_D102 && $past(state_q) != ST_D102) |-> $past(comwake_det_i));
  // R7
  rdy_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_rdy_o) |-> $past(rx_ctrl_i && rx_data_i == PRIM_SYNC));
  // R8
  linkup_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_rdy_o && $past(phy_rdy_o)) |-> (tx_data_o != $past(tx_data_o)));
  // R10
  cominit_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phy_rdy_o && cominit_det_i) |-> !phy_rdy_o);
endmodule

// File: tb/tb_link_oob_ctrl.sv
module tb_link_oob_ctrl;
  localparam int INIT_CYC  = 20;
  localparam int ALIGN_CYC = 16;
  localparam logic [31:0] K_ALIGN = 32'h7B4A4ABC;
  localparam logic [31:0] K_SYNC  = 32'hB5B5957C;
  localparam logic [31:0] K_D102  = 32'h4A4A4A4A;

  logic clk = 0, rst_ni = 0;
  logic burst_done = 0, cominit = 0, comwake = 0;
  logic [31:0] rx_data = 0;
  logic rx_ctrl = 0;
  logic comreset_req, comwake_req, tx_ctrl, phy_rdy;
  logic [31:0] tx_data;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  link_oob_ctrl #(.INIT_CYC(INIT_CYC), .ALIGN_CYC(ALIGN_CYC), .SYNC_RUN(3)) dut (
    .clk_i(clk), .rst_ni, .burst_done_i(burst_done), .cominit_det_i(cominit),
    .comwake_det_i(comwake), .rx_data_i(rx_data), .rx_ctrl_i(rx_ctrl),
    .comreset_req_o(comreset_req), .comwake_req_o(comwake_req),
    .tx_data_o(tx_data), .tx_ctrl_o(tx_ctrl), .phy_rdy_o(phy_rdy));

  // Reference model: phase 0 idle,1 await init,2 wake req,3 await wake,4 pattern,5 align,6 up
  int m_ph = 0, m_dwell = 0;
  bit m_alt = 0;
  bit sync_hist[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_dwell = 0; m_alt = 0; sync_hist.delete();
    end else begin
      int nxt;
      bit is_sync, bad;
      is_sync = rx_ctrl && rx_data == K_SYNC;
      bad = rx_ctrl && rx_data[7:0] != 8'hBC && rx_data[7:0] != 8'h7C;
      nxt = m_ph;
      if (m_ph == 5) begin
        if (is_sync) sync_hist.push_back(1'b1); else sync_hist.delete();
      end
      case (m_ph)
        0: if (burst_done) nxt = 1;
        1: if (cominit) nxt = 2; else if (m_dwell == INIT_CYC - 1) nxt = 0;
        2: if (burst_done) nxt = 3;
        3: if (comwake) nxt = 4;
        4: if (rx_ctrl && rx_data == K_ALIGN) nxt = 5; else if (m_dwell == ALIGN_CYC - 1) nxt = 0;
        5: if (sync_hist.size() >= 3) nxt = 6;
        6: if (cominit || bad) nxt = 0;
        default: nxt = 0;
      endcase
      m_alt = (m_ph == 6) ? !m_alt : 1'b0;
      if (nxt != m_ph) m_dwell = 0; else m_dwell++;
      if (nxt != 5) sync_hist.delete();
      m_ph = nxt;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  task automatic tick();
    logic [32:0] etx;
    @(negedge clk);
    cycles++;
    etx = 33'h0;
    if (m_ph == 4) etx = {1'b0, K_D102};
    if (m_ph == 5) etx = {1'b1, K_ALIGN};
    if (m_ph == 6) etx = m_alt ? {1'b1, K_SYNC} : {1'b1, K_ALIGN};
    chk(comreset_req == (m_ph == 0), "comreset_req", {32'b0, comreset_req}, {32'b0, m_ph == 0});
    chk(comwake_req == (m_ph == 2), "comwake_req", {32'b0, comwake_req}, {32'b0, m_ph == 2});
    chk(phy_rdy == (m_ph == 6), "phy_rdy", {32'b0, phy_rdy}, {32'b0, m_ph == 6});
    chk({tx_ctrl, tx_data} == etx, "tx_word", {tx_ctrl, tx_data}, etx);
  endtask

  task automatic pulse_done();  burst_done = 1; tick(); burst_done = 0; endtask
  task automatic pulse_init();  cominit = 1;    tick(); cominit = 0;    endtask
  task automatic pulse_wake();  comwake = 1;    tick(); comwake = 0;    endtask
  task automatic rx_word(input logic c, input logic [31:0] d); rx_ctrl = c; rx_data = d; tick(); endtask
  task automatic rx_idle(); rx_ctrl = 0; rx_data = 0; endtask

  task automatic bring_up();
    pulse_done(); tick(); pulse_init(); tick(); pulse_done(); tick(); pulse_wake();
    tick(); tick();
    rx_word(1, K_ALIGN);
    rx_word(1, K_SYNC); rx_word(1, K_SYNC); rx_word(1, K_SYNC);
    rx_idle(); tick();
  endtask

  initial begin
    while (cycles < 5000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected<5000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tag = "R1"; repeat (3) tick();
    rst_ni = 1; repeat (3) tick();
    // R3: wake pulse while idle has no effect
    tag = "R3"; pulse_wake(); tick();
    // R2: window expires, reset burst requested again
    tag = "R2"; pulse_done(); repeat (INIT_CYC + 4) tick();
    // R2: init pulse on last cycle of window accepted
    pulse_done(); repeat (INIT_CYC - 1) tick(); pulse_init();
    // R3: wake pulse during wake request ignored; then wait with no limit
    tag = "R3"; pulse_wake(); repeat (2) tick(); pulse_done(); repeat (40) tick();
    // R4 / R5: pattern then ALIGN timeout
    tag = "R4"; pulse_wake(); repeat (4) tick();
    tag = "R5"; rx_word(1, K_SYNC); rx_word(0, K_ALIGN); rx_idle(); repeat (ALIGN_CYC + 2) tick();
    // R6: broken runs before the full SYNC run
    tag = "R6";
    pulse_done(); pulse_init(); pulse_done(); pulse_wake(); tick();
    rx_word(1, K_ALIGN);
    rx_word(1, K_SYNC); rx_word(1, K_SYNC); rx_word(1, K_ALIGN);
    rx_word(1, K_SYNC); rx_word(0, K_SYNC); rx_word(1, K_SYNC); rx_word(1, K_SYNC);
    tag = "R7"; rx_word(1, K_SYNC);
    // R8: alternating transmit while up, valid traffic keeps link
    tag = "R8";
    for (int i = 0; i < 10; i++) rx_word(i[0], i[0] ? K_SYNC : 32'h1234_5678);
    rx_word(1, K_ALIGN);
    // R9: bad control word drops link
    tag = "R9"; rx_word(0, 32'hDEAD_BEEF); rx_word(1, 32'h1111_11AA); rx_idle(); repeat (3) tick();
    // R10: init pulse drops link
    tag = "R10"; bring_up(); repeat (3) tick(); pulse_init(); repeat (3) tick();
    rst_ni = 0; tag = "R1"; tick(); rst_ni = 1; tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule